// File: doc/BRIEF.md
# Multi-Event Circular Capture Buffer

This block records one channel's sample stream into an internal sample memory that is split into a run-time selectable number of equal event slots. While acquisition is running, incoming samples are written into the active slot as a ring. The slot therefore always holds the most recent samples. When a trigger is accepted, the block writes a programmed number of further samples and then freezes the slot as a finished event. Capture then moves at once into the next slot, so consecutive events lose no samples as long as a slot is free.

A separate read side drains frozen events oldest first over a valid/ready word stream. Each event starts with one header word that carries the trigger timestamp and the sample count. The samples follow in time order, starting with the oldest sample captured before the trigger. The read side and the write side work independently. Status pins report that at least one event is waiting, and that every slot is occupied.

The sample input has no back-pressure: a sample offered with `smp_valid` is either stored or, while every slot is occupied, dropped. On the read side a word moves on a clock edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_hdr` hold their values. `rd_ready` may be held low for any length of time; acquisition carries on into the free slots.

Top module: `evbuf_ring`

## Requirements
- R1: The active slot keeps the most recent S samples, where S = 2^DEPTH_LOG / 2^k is the slot size. A frozen event holds min(samples written into the slot, S) samples.
- R2: A sample offered in the same cycle as an accepted trigger counts as pre-trigger. After the trigger, exactly `post_cnt` further samples are written and the slot is then frozen. With `post_cnt` = 0 the slot freezes at the trigger edge. A `post_cnt` larger than S still writes that many samples, and the event keeps the last S of them.
- R3: After a freeze, a sample offered in the very next cycle is stored as the first sample of the next slot, provided that slot is free.
- R4: The slot count is 2^k, where k is `nbuf_sel` clamped to DEPTH_LOG. A larger `nbuf_sel` acts as DEPTH_LOG.
- R5: Events are read oldest first. The header word has `rd_hdr` = 1, the timestamp in bits [47:16] and the sample count in bits [15:0]. Each sample word that follows has `rd_hdr` = 0 and carries its sample zero-extended in the low bits, oldest first.
- R6: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_data` and `rd_hdr` stay unchanged.
- R7: `data_ready` is high exactly when at least one frozen event is unread.
- R8: `busy` is high exactly when every slot holds a frozen event. While `busy` is high, offered samples are dropped and triggers are refused. Capture resumes as soon as the reader frees a slot.
- R9: The timestamp counts clock cycles (10 ns ticks) and is cleared to 0 by `ts_sync`. The header carries the count that the timestamp held in the cycle the trigger was accepted.
- R10: A trigger that arrives while `run` is high and either every slot is occupied or a post-trigger fill is in progress is refused and adds one to `rej_cnt`, which saturates. Triggers while `run` is low neither capture nor count.
- R11: `nbuf_sel` takes effect only while `run` is low. A change of the clamped value discards all stored events, restarts both sides at slot 0, and drops `data_ready` and `busy` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Acquisition enable |
| nbuf_sel | input | SEL_W | Log2 of the slot count |
| post_cnt | input | POST_W | Samples to write after a trigger |
| ts_sync | input | 1 | Clears the timestamp |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | DATA_W | Sample value |
| trig | input | 1 | Trigger request |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Reader accepts the word |
| rd_data | output | 48 | Header or sample word |
| rd_hdr | output | 1 | Current word is a header |
| data_ready | output | 1 | At least one event is waiting |
| busy | output | 1 | All slots hold frozen events |
| rej_cnt | output | REJ_W | Refused trigger count |

## Verification
The bench builds the block with DATA_W = 14 and DEPTH_LOG = 4, giving a 16-sample memory and a 3-bit slot selector. At that size every slot count from one 16-sample slot down to sixteen 1-sample slots can be exercised, as can a selector value beyond the clamp and the wrap of the ring inside 2-, 4- and 8-sample slots. With only two slots in use, the all-occupied state, the dropping of samples and the refusal of triggers come within a few dozen cycles. So do the hand-off to the next slot in the cycle after a freeze and the discarding of events on a slot-count change.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
  localparam int TS_W  = 32;
  localparam int LEN_W = 16;
  localparam int OUT_W = TS_W + LEN_W;

  typedef enum logic { W_ARM, W_POST } wr_state_t;
  typedef enum logic [1:0] { R_IDLE, R_HDR, R_DATA } rd_state_t;
endpackage

// File: rtl/evbuf_wr.sv
module evbuf_wr
  import evbuf_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int DEPTH_LOG = 10,
  parameter int POST_W    = 16,
  parameter int REJ_W     = 16,
  localparam int CNT_W    = DEPTH_LOG + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 cfg_clr,
  input  logic                 busy,
  input  logic                 smp_valid,
  input  logic                 trig,
  input  logic [POST_W-1:0]    post_cnt,
  input  logic [TS_W-1:0]      ts,
  input  logic [DEPTH_LOG-1:0] slot_mask,
  input  logic [DEPTH_LOG-1:0] off_mask,
  input  logic [CNT_W-1:0]     size,
  output logic                 wr_en,
  output logic [DEPTH_LOG-1:0] wr_slot,
  output logic [DEPTH_LOG-1:0] wr_off,
  output logic                 freeze,
  output logic [TS_W-1:0]      frz_ts,
  output logic [LEN_W-1:0]     frz_len,
  output logic [DEPTH_LOG-1:0] frz_start,
  output logic [REJ_W-1:0]     rej_cnt
);
  wr_state_t            state;
  logic [CNT_W-1:0]     fill, fill_nx;
  logic [DEPTH_LOG-1:0] off_nx;
  logic [POST_W-1:0]    post_left;
  logic [TS_W-1:0]      ts_lat;
  logic                 trig_ok, trig_rej, last_post;

  assign wr_en     = run && smp_valid && !busy;
  assign trig_ok   = run && trig && !busy && (state == W_ARM);
  assign trig_rej  = run && trig && (busy || state == W_POST);
  assign off_nx    = wr_en ? ((wr_off + 1'b1) & off_mask) : wr_off;
  assign fill_nx   = (wr_en && fill != size) ? fill + 1'b1 : fill;
  assign last_post = (state == W_POST) && wr_en && (post_left == POST_W'(1));
  assign freeze    = (trig_ok && post_cnt == '0) || last_post;
  assign frz_ts    = (state == W_ARM) ? ts : ts_lat;
  assign frz_len   = LEN_W'(fill_nx);
  assign frz_start = (fill_nx == size) ? off_nx : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= W_ARM;
      wr_slot   <= '0;
      wr_off    <= '0;
      fill      <= '0;
      post_left <= '0;
      ts_lat    <= '0;
    end else if (cfg_clr) begin
      state   <= W_ARM;
      wr_slot <= '0;
      wr_off  <= '0;
      fill    <= '0;
    end else if (freeze) begin
      state   <= W_ARM;
      wr_slot <= (wr_slot + 1'b1) & slot_mask;
      wr_off  <= '0;
      fill    <= '0;
    end else begin
      wr_off <= off_nx;
      fill   <= fill_nx;
      if (trig_ok) begin
        state     <= W_POST;
        post_left <= post_cnt;
        ts_lat    <= ts;
      end else if (state == W_POST && wr_en) begin
        post_left <= post_left - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rej_cnt <= '0;
    else if (trig_rej && !(&rej_cnt)) rej_cnt <= rej_cnt + 1'b1;
  end

  assert_post_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state == W_POST |-> !busy);
  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= size);
  assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == W_POST && trig && !cfg_clr && !freeze) |=> state == W_POST);
endmodule

// File: rtl/evbuf_rd.sv
module evbuf_rd
  import evbuf_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int DEPTH_LOG = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_clr,
  input  logic                 avail,
  input  logic [TS_W-1:0]      hdr_ts,
  input  logic [LEN_W-1:0]     hdr_len,
  input  logic [DEPTH_LOG-1:0] hdr_start,
  input  logic [DATA_W-1:0]    smp,
  input  logic [DEPTH_LOG-1:0] slot_mask,
  input  logic [DEPTH_LOG-1:0] off_mask,
  input  logic                 rd_ready,
  output logic                 rd_valid,
  output logic [OUT_W-1:0]     rd_data,
  output logic                 rd_hdr,
  output logic [DEPTH_LOG-1:0] rd_slot,
  output logic [DEPTH_LOG-1:0] rd_off,
  output logic                 release_evt
);
  rd_state_t            state;
  logic [DEPTH_LOG-1:0] idx;
  logic                 xfer;

  assign rd_valid    = (state != R_IDLE);
  assign rd_hdr      = (state == R_HDR);
  assign rd_off      = (hdr_start + idx) & off_mask;
  assign rd_data     = rd_hdr ? {hdr_ts, hdr_len} :
                       (state == R_DATA) ? OUT_W'(smp) : '0;
  assign xfer        = rd_valid && rd_ready;
  assign release_evt = xfer && ((rd_hdr && hdr_len == '0) ||
                       (state == R_DATA && LEN_W'(idx) == hdr_len - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= R_IDLE;
      rd_slot <= '0;
      idx     <= '0;
    end else if (cfg_clr) begin
      state   <= R_IDLE;
      rd_slot <= '0;
      idx     <= '0;
    end else if (release_evt) begin
      state   <= R_IDLE;
      rd_slot <= (rd_slot + 1'b1) & slot_mask;
    end else begin
      case (state)
        R_IDLE: if (avail) state <= R_HDR;
        R_HDR:  if (xfer) begin state <= R_DATA; idx <= '0; end
        R_DATA: if (xfer) idx <= idx + 1'b1;
        default: state <= R_IDLE;
      endcase
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n || cfg_clr)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_hdr)));
  assert_valid_has_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> avail);
endmodule

// File: rtl/evbuf_ring.sv
module evbuf_ring
  import evbuf_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int DEPTH_LOG = 10,
  parameter int POST_W    = 16,
  parameter int REJ_W     = 16,
  localparam int DEPTH    = 1 << DEPTH_LOG,
  localparam int CNT_W    = DEPTH_LOG + 1,
  localparam int SEL_W    = $clog2(DEPTH_LOG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [SEL_W-1:0]  nbuf_sel,
  input  logic [POST_W-1:0] post_cnt,
  input  logic              ts_sync,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              trig,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [OUT_W-1:0]  rd_data,
  output logic              rd_hdr,
  output logic              data_ready,
  output logic              busy,
  output logic [REJ_W-1:0]  rej_cnt
);
  logic [SEL_W-1:0]     nlog, sel_c;
  logic                 cfg_clr;
  logic [CNT_W-1:0]     nbuf, size, frozen;
  logic [DEPTH_LOG-1:0] slot_mask, off_mask, size_log;
  logic [TS_W-1:0]      ts_q;

  logic                 wr_en, freeze, release_evt;
  logic [DEPTH_LOG-1:0] wr_slot, wr_off, frz_start, rd_slot, rd_off;
  logic [TS_W-1:0]      frz_ts;
  logic [LEN_W-1:0]     frz_len;

  logic [DATA_W-1:0]    mem     [DEPTH];
  logic [TS_W-1:0]      m_ts    [DEPTH];
  logic [LEN_W-1:0]     m_len   [DEPTH];
  logic [DEPTH_LOG-1:0] m_start [DEPTH];

  assign sel_c      = (nbuf_sel > SEL_W'(DEPTH_LOG)) ? SEL_W'(DEPTH_LOG) : nbuf_sel;
  assign cfg_clr    = !run && (sel_c != nlog);
  assign nbuf       = CNT_W'(1) << nlog;
  assign size       = (CNT_W'(1) << DEPTH_LOG) >> nlog;
  assign slot_mask  = DEPTH_LOG'(nbuf - 1'b1);
  assign off_mask   = DEPTH_LOG'(size - 1'b1);
  assign size_log   = DEPTH_LOG'(DEPTH_LOG) - DEPTH_LOG'(nlog);
  assign busy       = (frozen == nbuf);
  assign data_ready = (frozen != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nlog   <= '0;
      frozen <= '0;
      ts_q   <= '0;
    end else begin
      ts_q <= ts_sync ? '0 : ts_q + 1'b1;
      if (cfg_clr) begin
        nlog   <= sel_c;
        frozen <= '0;
      end else begin
        frozen <= frozen + CNT_W'(freeze) - CNT_W'(release_evt);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[(wr_slot << size_log) | wr_off] <= smp_data;
    if (freeze && !cfg_clr) begin
      m_ts[wr_slot]    <= frz_ts;
      m_len[wr_slot]   <= frz_len;
      m_start[wr_slot] <= frz_start;
    end
  end

  evbuf_wr #(.DATA_W(DATA_W), .DEPTH_LOG(DEPTH_LOG), .POST_W(POST_W), .REJ_W(REJ_W)) u_wr (
    .clk, .rst_n, .run, .cfg_clr, .busy, .smp_valid, .trig, .post_cnt,
    .ts(ts_q), .slot_mask, .off_mask, .size,
    .wr_en, .wr_slot, .wr_off, .freeze, .frz_ts, .frz_len, .frz_start, .rej_cnt
  );

  evbuf_rd #(.DATA_W(DATA_W), .DEPTH_LOG(DEPTH_LOG)) u_rd (
    .clk, .rst_n, .cfg_clr, .avail(data_ready),
    .hdr_ts(m_ts[rd_slot]), .hdr_len(m_len[rd_slot]), .hdr_start(m_start[rd_slot]),
    .smp(mem[(rd_slot << size_log) | rd_off]),
    .slot_mask, .off_mask, .rd_ready,
    .rd_valid, .rd_data, .rd_hdr, .rd_slot, .rd_off, .release_evt
  );

  assert_occ_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frozen <= nbuf);
  assert_freeze_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !release_evt && !cfg_clr) |=> frozen == $past(frozen) + 1'b1);
  assert_cfg_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clr |=> (!data_ready && !busy && !rd_valid));
  assert_sel_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(nlog));
endmodule

// File: tb/evbuf_ring_bench.sv
module evbuf_ring_bench;
  localparam int DW = 14;
  localparam int DL = 4;

  logic        clk = 0, rst_n = 0, run = 0, ts_sync = 0;
  logic [2:0]  nbuf_sel = 0;
  logic [15:0] post_cnt = 0;
  logic        smp_valid = 0, trig = 0, rd_ready = 0;
  logic [DW-1:0] smp_data = 0;
  logic        rd_valid, rd_hdr, data_ready, busy;
  logic [47:0] rd_data;
  logic [15:0] rej_cnt;

  int n_chk = 0, n_fail = 0;
  logic [31:0] bts, exp_ts, ts_a, ts_b;
  logic [DW-1:0] exp_s [16];

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bts <= 0; else bts <= ts_sync ? 32'd0 : bts + 1;

  evbuf_ring #(.DATA_W(DW), .DEPTH_LOG(DL)) u_evbuf_ring (
    .clk, .rst_n, .run, .nbuf_sel, .post_cnt, .ts_sync, .smp_valid, .smp_data,
    .trig, .rd_valid, .rd_ready, .rd_data, .rd_hdr, .data_ready, .busy, .rej_cnt);

  // sel, pre samples, post samples, expected length, expected busy
  localparam int TBL [7][5] = '{
    '{2, 2, 1, 3, 0}, '{2, 6, 1, 4, 0}, '{0, 5, 3, 8, 1}, '{1, 3, 0, 3, 0},
    '{3, 1, 5, 2, 0}, '{4, 3, 0, 1, 0}, '{7, 2, 2, 1, 0}};

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] v, input logic t, input logic vld);
    @(negedge clk);
    smp_valid = vld; smp_data = v; trig = t;
    if (t) exp_ts = bts;
  endtask

  task automatic idle();
    @(negedge clk);
    smp_valid = 0; trig = 0; ts_sync = 0;
  endtask

  task automatic read_evt(input string req, input logic [31:0] ts, input int len);
    int k = 0;
    int guard = 0;
    while (k <= len && guard < 200) begin
      @(negedge clk);
      guard++;
      if (rd_valid) begin
        if (k == 0) begin
          chk({req, " header"}, {rd_hdr, rd_data}, {1'b1, ts, 16'(len)});
        end else begin
          chk({req, " sample"}, {rd_hdr, rd_data}, {1'b0, 34'd0, exp_s[k-1]});
        end
        rd_ready = 1;
        k++;
      end else begin
        rd_ready = 0;
      end
    end
    if (k <= len) chk({req, " words"}, 48'(k), 48'(len + 1));
    @(negedge clk);
    rd_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R7 reset data_ready", 48'(data_ready), 0);
    chk("R8 reset busy", 48'(busy), 0);
    chk("R5 reset rd_valid", 48'(rd_valid), 0);
    chk("R10 reset rej", 48'(rej_cnt), 0);
    rst_n = 1;

    // table of events: R1 R2 R4 R5 R9
    for (int r = 0; r < 7; r++) begin
      int p, n, len;
      p = TBL[r][1]; n = TBL[r][2]; len = TBL[r][3];
      @(negedge clk);
      run = 0; nbuf_sel = 3'(TBL[r][0]); post_cnt = 16'(n);
      @(negedge clk);
      @(negedge clk);
      chk("R11 empty after select", 48'(data_ready), 0);
      run = 1;
      for (int i = 0; i < p; i++) push(DW'((r << 6) | i), 0, 1);
      push(0, 1, 0);
      for (int i = 0; i < n; i++) push(DW'((r << 6) | (p + i)), 0, 1);
      idle();
      chk("R7 ready after freeze", 48'(data_ready), 1);
      chk("R4 busy per slot count", 48'(busy), 48'(TBL[r][4]));
      for (int k = 0; k < len; k++) exp_s[k] = DW'((r << 6) | (p + n - len + k));
      read_evt("R1 R2 R4 R5 R9 table", exp_ts, len);
      chk("R7 empty after read", 48'(data_ready), 0);
    end

    // two slots of 8: busy, refusal, no dead time, ordering
    @(negedge clk);
    run = 0; nbuf_sel = 1; post_cnt = 2;
    @(negedge clk); @(negedge clk);
    run = 1;
    push(14'h100, 0, 1); push(14'h101, 0, 1); push(0, 1, 0); ts_a = exp_ts;
    push(14'h102, 1, 1);
    push(14'h103, 0, 1);
    push(14'h110, 0, 1);            // R3: cycle right after the freeze
    push(0, 1, 0); ts_b = exp_ts;
    push(14'h111, 0, 1); push(14'h112, 0, 1);
    idle();
    chk("R8 busy when all slots full", 48'(busy), 1);
    chk("R10 trigger during post fill refused", 48'(rej_cnt), 1);
    push(14'h1F0, 0, 1); push(14'h1F1, 1, 1);
    idle();
    chk("R10 trigger while busy refused", 48'(rej_cnt), 2);
    @(negedge clk); nbuf_sel = 0;
    @(negedge clk); @(negedge clk);
    chk("R11 select ignored while running", 48'(busy), 1);
    nbuf_sel = 1;
    rd_ready = 0;
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      chk("R6 stalled header held", {rd_valid, rd_hdr, rd_data}, {2'b11, ts_a, 16'd4});
    end
    exp_s[0] = 14'h100; exp_s[1] = 14'h101; exp_s[2] = 14'h102; exp_s[3] = 14'h103;
    read_evt("R5 R10 oldest event", ts_a, 4);
    chk("R8 busy clears after read", 48'(busy), 0);
    exp_s[0] = 14'h110; exp_s[1] = 14'h111; exp_s[2] = 14'h112;
    read_evt("R3 R8 second event", ts_b, 3);
    chk("R7 drained", 48'(data_ready), 0);

    // triggers while stopped
    @(negedge clk); run = 0;
    push(0, 1, 0);
    idle();
    chk("R10 stopped trigger not counted", 48'(rej_cnt), 2);
    chk("R10 stopped trigger no capture", 48'(data_ready), 0);

    // slot-count change discards events
    @(negedge clk); run = 1;
    push(14'h120, 0, 1); push(0, 1, 0); push(14'h121, 0, 1); push(14'h122, 0, 1);
    idle();
    chk("R7 event stored", 48'(data_ready), 1);
    run = 0; nbuf_sel = 2;
    @(negedge clk); @(negedge clk);
    chk("R11 change clears ready", 48'(data_ready), 0);
    chk("R11 change clears busy", 48'(busy), 0);
    chk("R11 change idles reader", 48'(rd_valid), 0);

    // timestamp sync
    post_cnt = 1; run = 1;
    @(negedge clk); ts_sync = 1;
    @(negedge clk); ts_sync = 0;
    @(negedge clk);
    push(0, 1, 0);
    push(14'h2AA, 0, 1);
    idle();
    exp_s[0] = 14'h2AA;
    read_evt("R9 synced timestamp", 32'd2, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule